// File: doc/BRIEF.md
# T1 Receive Line Event Monitor

This block watches the recovered bipolar receive stream of a T1 line and turns line and framing problems into sticky status flags. Each bit time, qualified by a bit-clock enable, it sees one dual-rail symbol (a positive-pulse rail and a negative-pulse rail). A strobe marks the framing bit position and comes with the framing bit value the aligner expects there. A separate pulse from the frame aligner reports that a resync ended at a different frame or multiframe position.

The monitor finds runs of consecutive zeros at two lengths. It recognises the B8ZS substitution codeword whatever line code is in use, so software can pick the line coding on its own. It flags single framing bit errors, and it flags severely errored framing when two of the last six framing bits were wrong. All flags are latched into one status byte. The host reads the byte and clears bits by writing ones to them. The byte never raises an interrupt.

Top module: `t1_line_event_mon`

## Requirements
- R1: Status bit 0 sets on the bit-enable edge that delivers the eighth consecutive zero symbol (neither rail high). A run of seven zeros followed by a mark leaves it clear.
- R2: Status bit 1 sets on the edge that delivers the sixteenth consecutive zero symbol. A run of fifteen zeros followed by a mark leaves it clear.
- R3: A mark on either rail restarts the zero run. The run count saturates, so in a run of any length every further zero re-reports both zero events, including right after they are cleared.
- R4: Status bit 2 sets when the last eight symbols form 000VB0VB. A positive mark is pos=1,neg=0 and a negative mark is pos=0,neg=1. V has the same polarity as the mark before it, and B has the polarity opposite the mark before it. This holds for both starting polarities, and the bit is set without regard to any line-code setting. A fully alternating sequence with the same zero positions does not set it.
- R5: Status bit 3 sets when, on a framing strobe, the received bit (1 when either rail is high) differs from the expected framing value.
- R6: Status bit 4 sets when the current framing bit and the five framing bits before it hold at least two errors. Two errors six framing positions apart do not set it.
- R7: Status bit 5 sets one cycle after the realign input is high.
- R8: Writing with clr_we high clears every status bit whose clr_data bit is 1 and leaves the others unchanged. An event in the same cycle as its clear leaves the bit set.
- R9: Status bits 7 and 6 always read 0, and status is 0x00 after reset.
- R10: Symbols and strobes presented while bit_en is low have no effect on the zero run, the framing history or the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Qualifies one received bit time |
| rx_pos | input | 1 | Positive-pulse rail |
| rx_neg | input | 1 | Negative-pulse rail |
| fbit_stb | input | 1 | Marks the framing bit position |
| fbit_exp | input | 1 | Expected framing bit value |
| realign | input | 1 | Pulse: resync changed the frame/multiframe position |
| clr_we | input | 1 | Write strobe for clearing status |
| clr_data | input | 8 | Write-one-to-clear mask |
| status | output | 8 | Latched event byte: [0] 8 zeros, [1] 16 zeros, [2] B8ZS code, [3] framing bit error, [4] severely errored framing, [5] realign, [7:6] zero |

## Verification
Zero runs of seven, eight, fifteen and sixteen bits separate the two thresholds, and a long run cleared partway through shows that the saturating count cannot wrap. The substitution codeword is sent after a positive mark and after a negative mark, and an alternating look-alike is sent with the same zero positions; together these show that the check is on violation polarity and not only on where the zeros fall. Framing errors six positions apart and two positions apart tell the sliding six-bit window from a plain error count. Symbols sent with bit_en low, writes of zeros, and a clear in the same cycle as an event confirm the gating and the clear priority.

// File: rtl/t1_line_event_mon.sv
module t1_line_event_mon #(
  parameter int LOW_RUN  = 8,
  parameter int HIGH_RUN = 16,
  parameter int SEF_WIN  = 6,
  parameter int SEF_HITS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       rx_pos,
  input  logic       rx_neg,
  input  logic       fbit_stb,
  input  logic       fbit_exp,
  input  logic       realign,
  input  logic       clr_we,
  input  logic [7:0] clr_data,
  output logic [7:0] status
);
  localparam int RW = $clog2(HIGH_RUN + 1);
  localparam logic [RW-1:0] RMAX = RW'(HIGH_RUN);
  localparam logic [RW-1:0] RLOW = RW'(LOW_RUN);
  localparam logic [1:0] PMARK = 2'b10;
  localparam logic [1:0] NMARK = 2'b01;

  logic          mark;
  logic [RW-1:0] run_q, run_d;
  logic [1:0]    sym;
  logic [1:0]    win [8];
  logic          prev_pol, prev_ok;
  logic          pol_now, pol_ok;
  logic [1:0]    ps, ns;
  logic          b8_hit;
  logic [SEF_WIN-2:0] fhist;
  logic          ferr;
  logic [5:0]    ev;

  assign mark  = rx_pos | rx_neg;
  assign sym   = {rx_pos, rx_neg};
  assign run_d = mark ? '0 : (run_q == RMAX ? RMAX : run_q + 1'b1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run_q <= '0;
    else if (bit_en) run_q <= run_d;

  // polarity of the last mark before the eight-symbol window that ends now
  assign pol_ok  = (win[7] == PMARK || win[7] == NMARK) ? 1'b1 : prev_ok;
  assign pol_now = (win[7] == PMARK || win[7] == NMARK) ? win[7][1] : prev_pol;
  assign ps = pol_now ? PMARK : NMARK;
  assign ns = pol_now ? NMARK : PMARK;
  assign b8_hit = pol_ok && win[6] == 2'b00 && win[5] == 2'b00 && win[4] == 2'b00 &&
                  win[3] == ps && win[2] == ns && win[1] == 2'b00 &&
                  win[0] == ns && sym == ps;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) win[i] <= 2'b00;
      prev_pol <= 1'b0;
      prev_ok  <= 1'b0;
    end else if (bit_en) begin
      win[0] <= sym;
      for (int i = 1; i < 8; i++) win[i] <= win[i-1];
      prev_pol <= pol_now;
      prev_ok  <= pol_ok;
    end

  assign ferr = bit_en & fbit_stb & (mark ^ fbit_exp);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fhist <= '0;
    else if (bit_en && fbit_stb) fhist <= {fhist[SEF_WIN-3:0], ferr};

  assign ev[0] = bit_en & (run_d >= RLOW);
  assign ev[1] = bit_en & (run_d == RMAX);
  assign ev[2] = bit_en & b8_hit;
  assign ev[3] = ferr;
  assign ev[4] = ferr & (32'($countones(fhist)) + 32'd1 >= SEF_HITS);
  assign ev[5] = realign;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) status <= 8'h00;
    else status <= {2'b00, (status[5:0] & ~({6{clr_we}} & clr_data[5:0])) | ev};
endmodule

// File: rtl/t1_line_event_mon_chk.sv
module t1_line_event_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       rx_pos,
  input logic       rx_neg,
  input logic       fbit_stb,
  input logic       fbit_exp,
  input logic       realign,
  input logic       clr_we,
  input logic [7:0] clr_data,
  input logic [7:0] status
);
  a_r9_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:6] == 2'b00);

  a_r7_realign: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> status[5]);

  a_r5_fbit_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && fbit_stb && ((rx_pos | rx_neg) != fbit_exp)) |=> status[3]);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> (($past(status) & ~status) == 8'h00));

  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (realign && clr_we && clr_data[5]) |=> status[5]);

  a_r10_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !realign && !clr_we) |=> $stable(status));
endmodule

bind t1_line_event_mon t1_line_event_mon_chk u_chk (.*);

// File: tb/t1_line_event_mon_test.sv
module t1_line_event_mon_test;
  localparam int CLK_PER = 10;

  logic clk = 0, rst_n = 0, bit_en = 0, rx_pos = 0, rx_neg = 0;
  logic fbit_stb = 0, fbit_exp = 0, realign = 0, clr_we = 0;
  logic [7:0] clr_data = 0;
  logic [7:0] status;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  t1_line_event_mon uut (.*);

  task automatic chk(string rq, logic [7:0] mask, logic [7:0] exp);
    n_chk++;
    if ((status & mask) !== (exp & mask)) begin
      n_bad++;
      $display("FAIL %s: status=%h expected=%h (mask %h)", rq, status & mask, exp & mask, mask);
    end
  endtask

  task automatic sendsym(logic [1:0] s, logic fs = 0, logic fe = 0, logic en = 1);
    @(negedge clk);
    {rx_pos, rx_neg} = s; fbit_stb = fs; fbit_exp = fe; bit_en = en;
    @(negedge clk);
    bit_en = 0; fbit_stb = 0; {rx_pos, rx_neg} = 2'b00;
  endtask

  task automatic clear_all();
    @(negedge clk); clr_we = 1; clr_data = 8'hFF;
    @(negedge clk); clr_we = 0; clr_data = 0;
  endtask

  task automatic zeros(int n);
    for (int i = 0; i < n; i++) sendsym(2'b00);
  endtask

  task automatic t_reset();
    chk("R9 reset", 8'hFF, 8'h00);
  endtask

  task automatic t_zero_runs();
    sendsym(2'b10); clear_all();
    zeros(7); chk("R1 seven zeros", 8'h01, 8'h00);
    sendsym(2'b01); zeros(7); chk("R3 mark restarts run", 8'h01, 8'h00);
    zeros(1); chk("R1 eighth zero", 8'h03, 8'h01);
    sendsym(2'b10); clear_all();
    zeros(15); chk("R2 fifteen zeros", 8'h02, 8'h00);
    sendsym(2'b10); clear_all();
    zeros(16); chk("R2 sixteen zeros", 8'h03, 8'h03);
    zeros(30); clear_all(); chk("R8 clear mid-run", 8'h03, 8'h00);
    zeros(1); chk("R3 saturated run re-reports", 8'h03, 8'h03);
    sendsym(2'b10); clear_all();
  endtask

  task automatic t_b8zs();
    sendsym(2'b10); clear_all();
    zeros(3); sendsym(2'b10); sendsym(2'b01); zeros(1); sendsym(2'b01); sendsym(2'b10);
    chk("R4 codeword after positive mark", 8'h04, 8'h04);
    clear_all();
    sendsym(2'b01);
    zeros(3); sendsym(2'b01); sendsym(2'b10); zeros(1); sendsym(2'b10); sendsym(2'b01);
    chk("R4 codeword after negative mark", 8'h04, 8'h04);
    clear_all();
    sendsym(2'b10);
    zeros(3); sendsym(2'b01); sendsym(2'b10); zeros(1); sendsym(2'b01); sendsym(2'b10);
    chk("R4 alternating look-alike", 8'h04, 8'h00);
  endtask

  task automatic t_framing();
    clear_all();
    sendsym(2'b10, 1, 1); chk("R5 good framing bit", 8'h18, 8'h00);
    sendsym(2'b00, 1, 1); chk("R5 framing bit error", 8'h18, 8'h08);
    for (int i = 0; i < 5; i++) sendsym(2'b10, 1, 1);
    clear_all();
    sendsym(2'b01, 1, 0); chk("R6 errors six apart", 8'h18, 8'h08);
    sendsym(2'b00, 1, 1); chk("R6 two errors in window", 8'h10, 8'h10);
  endtask

  task automatic t_realign_clear();
    clear_all();
    @(negedge clk); realign = 1; @(negedge clk); realign = 0;
    chk("R7 realign latched", 8'h20, 8'h20);
    @(negedge clk); clr_we = 1; clr_data = 8'h00; @(negedge clk); clr_we = 0;
    chk("R8 zero write keeps bits", 8'h20, 8'h20);
    @(negedge clk); clr_we = 1; clr_data = 8'h20; realign = 1;
    @(negedge clk); clr_we = 0; clr_data = 0; realign = 0;
    chk("R8 event wins over clear", 8'h20, 8'h20);
    @(negedge clk); clr_we = 1; clr_data = 8'h20; @(negedge clk); clr_we = 0;
    chk("R8 write one clears", 8'hFF, 8'h00);
  endtask

  task automatic t_gating();
    sendsym(2'b10); clear_all();
    for (int i = 0; i < 20; i++) sendsym(2'b00, 1, 1, 0);
    chk("R10 gated symbols ignored", 8'hFF, 8'h00);
    zeros(7); chk("R10 run not advanced while gated", 8'h01, 8'h00);
    sendsym(2'b10); clear_all();
    chk("R9 top bits zero", 8'hC0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_zero_runs();
    t_b8zs();
    t_framing();
    t_realign_clear();
    t_gating();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule